// File: doc/BRIEF.md
# Inter-core exchange port crossbar

Each of several processor cores owns a private internal exchange port. A core forms its port output from its output register, ORs in a contribution from its own peripherals, and then masks the result with its direction register. The core outputs are never merged into one shared bus. Instead, every core holds a filter register that decides, separately for each byte lane, which cores' outputs it ORs together into its own exchange input word. That filtered word also goes to the reading core's peripherals.

Register writes and peripheral changes reach the exchange inputs through a fixed two-stage pipeline. A core that issues a write therefore sees the result on the third clock. Counting the edge that captures the write as the first, the two reads that follow still return data formed under the old settings.

Top module: `xchg_crossbar`

## Requirements
- R1: The port output of core c, `port_o[c*32 +: 32]`, equals (output register OR `periph_i[c*32 +: 32]`) AND direction register. It follows register and peripheral changes with no pipeline delay, and every bit whose direction bit is 0 reads 0.
- R2: In core r's filter register, bits [8L+7:8L] control input lane L, which is bits [8L+7:8L] of `xin_o[r*32 +: 32]`. Bit n of that field set ORs byte lane L of core n's port output into that lane.
- R3: An input lane whose filter field is all zeros reads 0x00.
- R4: Filter value 0x01010101 passes core 0's full port output unchanged. Filter value 0x03030303 passes the bitwise OR of the port outputs of core 0 and core 1.
- R5: A filter write captured at rising edge t shows at `xin_o` only after edge t+2. Samples taken after edges t and t+1 still reflect the old filter.
- R6: An output-register write captured at edge t reaches every selecting core's `xin_o` after edge t+2, and not before.
- R7: A change on `periph_i` during the cycle before edge t appears on `port_o` at once and on `xin_o` after edge t+1.
- R8: Active-low asynchronous reset clears all output, direction and filter registers and the pipeline, so both `port_o` and `xin_o` read 0.
- R9: Each core's output, direction and filter strobes are independent. A write through one strobe leaves that core's other two registers, and the registers of every other core, unchanged.
- R10: A core may select its own port output in its filter and reads it back like any other core's output.
- R11: Once no strobe is asserted and `periph_i` is held steady for three consecutive clocks, `xin_o` is stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| out_we_i | input | 8 | Per-core output register write strobe |
| dir_we_i | input | 8 | Per-core direction register write strobe |
| flt_we_i | input | 8 | Per-core filter register write strobe |
| wdata_i | input | 256 | Per-core write data, core c in bits [c*32 +: 32] |
| periph_i | input | 256 | Per-core peripheral output contribution |
| port_o | output | 256 | Per-core masked exchange port output |
| xin_o | output | 256 | Per-core filtered exchange input, also fed to that core's peripherals |

## Verification
The hardest thing to reach from the ports is a case where three changes stack up in one pipeline window: a filter write, an output write by a different core, and a peripheral change all sit in flight together. Each one has a different visibility edge. A cycle-accurate reference model keeps a two-deep history of the combined input word for this. After directed steps that pin the lane mapping, the self-select case and the exact old/new boundaries with literal values, a long random phase drives overlapping strobes on all cores while also toggling `periph_i`. That phase compares every core's input and output on every clock.

// File: rtl/xchg_pkg.sv
package xchg_pkg;
  parameter int unsigned XCHG_CORES  = 8;
  parameter int unsigned XCHG_LANE_W = 8;
  parameter int unsigned XCHG_LANES  = 4;
  parameter int unsigned XCHG_DEPTH  = 2;
endpackage

// File: rtl/xchg_core_regs.sv
module xchg_core_regs #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         out_we_i,
  input  logic         dir_we_i,
  input  logic         flt_we_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] periph_i,
  output logic [W-1:0] port_o,
  output logic [W-1:0] dir_o,
  output logic [W-1:0] flt_o
);
  logic [W-1:0] out_q, dir_q, flt_q;

  // R9: independent strobes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= '0;
      dir_q <= '0;
      flt_q <= '0;
    end else begin
      if (out_we_i) out_q <= wdata_i;
      if (dir_we_i) dir_q <= wdata_i;
      if (flt_we_i) flt_q <= wdata_i;
    end
  end

  assign port_o = (out_q | periph_i) & dir_q;
  assign dir_o  = dir_q;
  assign flt_o  = flt_q;
endmodule

// File: rtl/xchg_lane_sel.sv
module xchg_lane_sel #(
  parameter int unsigned N     = 8,
  parameter int unsigned LANE_W = 8,
  parameter int unsigned LANES = 4,
  localparam int unsigned W    = LANE_W * LANES
) (
  input  logic [N*W-1:0] ports_i,
  input  logic [W-1:0]   flt_i,
  output logic [W-1:0]   xin_o
);
  // filter field bit n selects core n, so a lane must be at least N bits wide
  if (N > LANE_W) begin : g_bad_cfg
    $error("xchg_lane_sel: N exceeds LANE_W");
  end

  always_comb begin
    xin_o = '0;
    for (int l = 0; l < LANES; l++) begin
      for (int n = 0; n < N; n++) begin
        if (flt_i[l*LANE_W + n])
          xin_o[l*LANE_W +: LANE_W] = xin_o[l*LANE_W +: LANE_W] | ports_i[n*W + l*LANE_W +: LANE_W];
      end
    end
  end
endmodule

// File: rtl/xchg_delay.sv
module xchg_delay #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [DEPTH];

  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else         stage_q[s] <= (s == 0) ? d_i : stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[DEPTH-1];
endmodule

// File: rtl/xchg_crossbar.sv
module xchg_crossbar
  import xchg_pkg::*;
#(
  parameter int unsigned N      = XCHG_CORES,
  parameter int unsigned LANE_W = XCHG_LANE_W,
  parameter int unsigned LANES  = XCHG_LANES,
  parameter int unsigned DEPTH  = XCHG_DEPTH,
  localparam int unsigned W     = LANE_W * LANES
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [N-1:0]   out_we_i,
  input  logic [N-1:0]   dir_we_i,
  input  logic [N-1:0]   flt_we_i,
  input  logic [N*W-1:0] wdata_i,
  input  logic [N*W-1:0] periph_i,
  output logic [N*W-1:0] port_o,
  output logic [N*W-1:0] xin_o
);
  logic [N*W-1:0] port_all, dir_all, flt_all, xin_comb;

  for (genvar c = 0; c < N; c++) begin : g_core
    xchg_core_regs #(.W(W)) u_regs (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .out_we_i (out_we_i[c]),
      .dir_we_i (dir_we_i[c]),
      .flt_we_i (flt_we_i[c]),
      .wdata_i  (wdata_i[c*W +: W]),
      .periph_i (periph_i[c*W +: W]),
      .port_o   (port_all[c*W +: W]),
      .dir_o    (dir_all[c*W +: W]),
      .flt_o    (flt_all[c*W +: W])
    );

    xchg_lane_sel #(.N(N), .LANE_W(LANE_W), .LANES(LANES)) u_sel (
      .ports_i (port_all),
      .flt_i   (flt_all[c*W +: W]),
      .xin_o   (xin_comb[c*W +: W])
    );

    // R5 R6 R7: write-to-read latency
    xchg_delay #(.W(W), .DEPTH(DEPTH)) u_dly (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (xin_comb[c*W +: W]),
      .q_o    (xin_o[c*W +: W])
    );
  end

  assign port_o = port_all;
endmodule

// File: rtl/xchg_checker.sv
module xchg_checker #(
  parameter int unsigned N      = 8,
  parameter int unsigned LANE_W = 8,
  parameter int unsigned LANES  = 4,
  localparam int unsigned W     = LANE_W * LANES
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic [N-1:0]   out_we_i,
  input logic [N-1:0]   dir_we_i,
  input logic [N-1:0]   flt_we_i,
  input logic [N*W-1:0] periph_i,
  input logic [N*W-1:0] port_o,
  input logic [N*W-1:0] xin_o,
  input logic [N*W-1:0] dir_all,
  input logic [N*W-1:0] flt_all
);
  logic [1:0]     quiet_q;
  logic [N*W-1:0] periph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      quiet_q  <= '0;
      periph_q <= '0;
    end else begin
      periph_q <= periph_i;
      if ((|{out_we_i, dir_we_i, flt_we_i}) || (periph_i != periph_q)) quiet_q <= '0;
      else if (quiet_q != 2'd3) quiet_q <= quiet_q + 2'd1;
    end
  end

  a_r8_reset_clear: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (xin_o == '0 && port_o == '0));

  a_r1_dir_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (port_o & ~dir_all) == '0);

  a_r11_quiet_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    quiet_q == 2'd3 |-> $stable(xin_o));

  for (genvar r = 0; r < N; r++) begin : g_rd
    for (genvar l = 0; l < LANES; l++) begin : g_ln
      a_r3_zero_lane: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(flt_all[r*W + l*LANE_W +: LANE_W], 2) == '0 |->
          xin_o[r*W + l*LANE_W +: LANE_W] == '0);
    end
  end
endmodule

bind xchg_crossbar xchg_checker #(.N(N), .LANE_W(LANE_W), .LANES(LANES)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .out_we_i (out_we_i),
  .dir_we_i (dir_we_i),
  .flt_we_i (flt_we_i),
  .periph_i (periph_i),
  .port_o   (port_o),
  .xin_o    (xin_o),
  .dir_all  (dir_all),
  .flt_all  (flt_all)
);

// File: tb/tb_xchg_crossbar.sv
`timescale 1ns/1ps
module tb_xchg_crossbar;
  localparam int N = 8;
  localparam int W = 32;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [N-1:0]   out_we = '0, dir_we = '0, flt_we = '0;
  logic [N*W-1:0] wdata = '0, periph = '0;
  logic [N*W-1:0] port_o, xin_o;

  always #2.5 clk = ~clk;

  xchg_crossbar dut (
    .clk_i(clk), .rst_ni(rst_n), .out_we_i(out_we), .dir_we_i(dir_we),
    .flt_we_i(flt_we), .wdata_i(wdata), .periph_i(periph),
    .port_o(port_o), .xin_o(xin_o)
  );

  int n_cmp = 0, n_bad = 0;
  string tag = "R8";
  logic [W-1:0] m_out [N], m_dir [N], m_flt [N];
  logic [N*W-1:0] h1 = '0, h2 = '0;

  function automatic logic [W-1:0] m_port(int c);
    return (m_out[c] | periph[c*W +: W]) & m_dir[c];
  endfunction

  function automatic logic [N*W-1:0] m_xin();
    logic [N*W-1:0] v = '0;
    for (int r = 0; r < N; r++)
      for (int l = 0; l < 4; l++)
        for (int n = 0; n < N; n++)
          if (m_flt[r][l*8+n]) v[r*W + l*8 +: 8] |= m_port(n) >> (l*8);
    return v;
  endfunction

  task automatic chk(string t, logic [N*W-1:0] act, logic [N*W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", t, act, exp);
    end
  endtask

  task automatic chk32(string t, logic [W-1:0] act, logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", t, act, exp);
    end
  endtask

  // one clock: model update at the edge, compare at the falling edge
  task automatic tick();
    logic [N*W-1:0] pv;
    @(posedge clk);
    h2 = h1;
    h1 = m_xin();
    for (int c = 0; c < N; c++) begin
      if (out_we[c]) m_out[c] = wdata[c*W +: W];
      if (dir_we[c]) m_dir[c] = wdata[c*W +: W];
      if (flt_we[c]) m_flt[c] = wdata[c*W +: W];
    end
    @(negedge clk);
    for (int c = 0; c < N; c++) pv[c*W +: W] = m_port(c);
    chk({tag, " port"}, port_o, pv);
    chk({tag, " xin"}, xin_o, h2);
    out_we = '0; dir_we = '0; flt_we = '0;
  endtask

  task automatic wr(int c, int kind, logic [W-1:0] v);
    wdata[c*W +: W] = v;
    if (kind == 0) out_we[c] = 1'b1;
    else if (kind == 1) dir_we[c] = 1'b1;
    else flt_we[c] = 1'b1;
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < N; c++) begin m_out[c] = '0; m_dir[c] = '0; m_flt[c] = '0; end
    #12;
    // R8: reset state
    chk("R8 port", port_o, '0);
    chk("R8 xin", xin_o, '0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: direction masks output
    tag = "R1";
    wr(0, 0, 32'h11223344); wr(1, 0, 32'h80000001); tick();
    chk32("R1 masked by zero dir", port_o[31:0], 32'h0);
    wr(0, 1, 32'hFFFFFFFF); wr(1, 1, 32'hFFFFFFFF); tick();
    chk32("R1 dir open", port_o[31:0], 32'h11223344);

    // R4: single and paired selection
    tag = "R4";
    wr(2, 2, 32'h01010101); wr(3, 2, 32'h03030303);
    repeat (3) tick();
    chk32("R4 core0 only", xin_o[2*W +: W], 32'h11223344);
    chk32("R4 core0|core1", xin_o[3*W +: W], 32'h91223345);

    // R2: per-lane field mapping
    tag = "R2";
    wr(4, 2, 32'h02010201); repeat (3) tick();
    chk32("R2 lane map", xin_o[4*W +: W], 32'h80220044);

    // R3: zero fields read zero
    tag = "R3";
    wr(4, 2, 32'h00030000); repeat (3) tick();
    chk32("R3 zero lanes", xin_o[4*W +: W], 32'h00220000);

    // R5: filter latency
    tag = "R5";
    wr(2, 2, 32'h02020202);
    tick(); chk32("R5 first read old", xin_o[2*W +: W], 32'h11223344);
    tick(); chk32("R5 second read old", xin_o[2*W +: W], 32'h11223344);
    tick(); chk32("R5 third read new", xin_o[2*W +: W], 32'h80000001);

    // R6: output write latency
    tag = "R6";
    wr(1, 0, 32'h00000100);
    tick(); chk32("R6 first read old", xin_o[2*W +: W], 32'h80000001);
    tick(); chk32("R6 second read old", xin_o[2*W +: W], 32'h80000001);
    tick(); chk32("R6 third read new", xin_o[2*W +: W], 32'h00000100);

    // R7: peripheral contribution
    tag = "R7";
    periph[1*W +: W] = 32'h00FF0000;
    #1 chk32("R7 port immediate", port_o[1*W +: W], 32'h00FF0100);
    tick(); chk32("R7 xin old", xin_o[2*W +: W], 32'h00000100);
    tick(); chk32("R7 xin new", xin_o[2*W +: W], 32'h00FF0100);

    // R9: dir write leaves out and filter
    tag = "R9";
    wr(1, 1, 32'h0000FFFF); tick();
    chk32("R9 out kept", port_o[1*W +: W], 32'h00000100);
    repeat (2) tick();
    chk32("R9 filter kept", xin_o[2*W +: W], 32'h00000100);

    // R10: self select
    tag = "R10";
    wr(5, 0, 32'hA5A5A5A5); tick();
    wr(5, 1, 32'hFFFFFFFF); tick();
    wr(5, 2, 32'h20202020); repeat (3) tick();
    chk32("R10 self", xin_o[5*W +: W], 32'hA5A5A5A5);

    // R11 and all: random overlapping traffic
    tag = "R11";
    for (int i = 0; i < 3000; i++) begin
      out_we = N'($urandom) & N'($urandom);
      dir_we = N'($urandom) & N'($urandom);
      flt_we = N'($urandom) & N'($urandom) & N'($urandom);
      for (int c = 0; c < N; c++) begin
        wdata[c*W +: W] = $urandom;
        if ($urandom_range(0, 3) == 0) periph[c*W +: W] = $urandom & $urandom;
      end
      if (i % 50 > 44) begin out_we = '0; dir_we = '0; flt_we = '0; end
      tick();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule